// File: doc/BRIEF.md
# Programmable Interval Timer

This block counts cycles of its own clock, down from a programmed interval value or up toward it, and raises a timeout flag every time the interval runs out. A prescaler stretches each step of the main count over several clocks, which extends the reachable range. The timer either stops after one interval or restarts by itself for as long as it stays enabled. Software drives it through a set of write strobes with data fields, and it sees the enable state, both counters, the raw flag and the masked interrupt as plain outputs.

The central promise is an exact period. A load value L with a prescale value P gives a timeout every (L+1)·(P+1) clocks. The single reload cycle is part of that count, so a long series of periodic timeouts never drifts against a free-running cycle counter on the same clock.

Control is a two-state machine. IDLE means the timer is stopped. RUN means it is counting. The transitions are:
- START: IDLE to RUN, on a control write with enable=1.
- STOP: RUN to IDLE, on a control write with enable=0.
- EXPIRE: RUN to IDLE, on a timeout in one-shot mode.
- RELOAD: RUN to RUN, on a timeout in periodic mode.

Top module: `interval_timer`

## Requirements
- R1: After reset, `run`, `cnt_val`, `pre_cnt`, `irq_raw` and `irq` are all 0.
- R2: A control write with `ctrl_en`=1 while idle makes `run`=1 at the next edge. That same edge loads `pre_cnt` with the prescale register and loads `cnt_val` with the load register (down, `ctrl_up`=0) or with 0 (up, `ctrl_up`=1).
- R3: While running, `pre_cnt` decrements every clock and `cnt_val` holds. When `pre_cnt` is 0, `pre_cnt` reloads the prescale value and `cnt_val` steps by one. In down mode the timeout cycle is the one with `cnt_val`=0 and `pre_cnt`=0.
- R4: In up mode `cnt_val` increments at each prescaler wrap. The timeout cycle is the one with `cnt_val` equal to the load value and `pre_cnt`=0, and the count then reloads with 0.
- R5: With load L and prescale P, periodic timeouts come exactly every (L+1)·(P+1) clocks, for as many periods as the timer runs.
- R6: In periodic mode the edge after the timeout cycle reloads the start value, and counting continues on the next clock.
- R7: In one-shot mode the edge after the timeout cycle reloads the start value, clears `run` and sets `irq_raw`. The counters then hold.
- R8: Load or prescale writes made while running leave the current interval unchanged and take effect at the next reload.
- R9: `irq_raw` is set at the edge after a timeout cycle and stays set until `irq_clr` is applied. When a timeout and `irq_clr` fall in the same cycle, the flag stays set.
- R10: `irq` is high exactly when `irq_raw` is 1 and the mask bit written with the last control write is 1.
- R11: A control write with `ctrl_en`=0 while running clears `run` at the next edge. Both counters then keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Strobe: write the control fields |
| ctrl_en | input | 1 | Enable value written with the control fields |
| ctrl_periodic | input | 1 | 1 = periodic, 0 = one-shot |
| ctrl_up | input | 1 | 1 = count up, 0 = count down |
| ctrl_mask | input | 1 | Interrupt mask, 1 passes the flag to `irq` |
| load_we | input | 1 | Strobe: write the load register |
| load_val | input | CNT_W | Interval load value |
| pre_we | input | 1 | Strobe: write the prescale register |
| pre_val | input | PRE_W | Prescale value |
| irq_clr | input | 1 | Clears the raw timeout flag |
| run | output | 1 | Enable state (1 in RUN) |
| cnt_val | output | CNT_W | Current main count |
| pre_cnt | output | PRE_W | Current prescaler count |
| irq_raw | output | 1 | Sticky raw timeout flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets these corner cases:
- **Period length over many intervals.** A design that adds or drops a clock at reload moves a timeout pulse off its multiple of (L+1)·(P+1) within a few periods.
- **Timeout and clear in the same cycle.** With the clear held high, a design that lets the clear win never shows the flag at all.
- **Load rewrite mid-interval.** A design that applies the new load at once cuts the running interval short.
- **Direction and mode.** A design that confuses the up terminal, or fails to drop enable after one shot, shows the wrong count sequence or stays in RUN.
- **Stopping and masking.** These show whether the counters freeze and whether the mask only gates the output.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic periodic;
        logic up;
        logic mask;
    } tmr_mode_t;

endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             ctrl_periodic,
    input  logic             ctrl_up,
    input  logic             ctrl_mask,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             pre_we,
    input  logic [PRE_W-1:0] pre_val,
    output tmr_mode_t        mode_q,
    output logic [CNT_W-1:0] load_q,
    output logic [PRE_W-1:0] pre_q
);

    // Mode bits are updated on every control write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (ctrl_we) begin
            mode_q.periodic <= ctrl_periodic;
            mode_q.up       <= ctrl_up;
            mode_q.mask     <= ctrl_mask;
        end
    end

    // Interval value and prescale value, each with its own strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            pre_q  <= '0;
        end else begin
            if (load_we) load_q <= load_val;
            if (pre_we)  pre_q  <= pre_val;
        end
    end

endmodule

// File: rtl/itmr_fsm.sv
module itmr_fsm
    import itmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       ctrl_en,
    input  logic       periodic,
    input  logic       terminal,
    output tmr_state_e state_q,
    output logic       start,
    output logic       stop,
    output logic       timeout
);

    tmr_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and transition outputs.
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        stop    = 1'b0;
        timeout = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_we && ctrl_en) begin
                    start   = 1'b1;       // START
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                timeout = terminal;
                if (ctrl_we && !ctrl_en) begin
                    stop    = 1'b1;       // STOP
                    state_d = ST_IDLE;
                end else if (terminal && !periodic) begin
                    state_d = ST_IDLE;    // EXPIRE
                end else begin
                    state_d = ST_RUN;     // RELOAD or keep counting
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             running,
    input  logic             start_up,
    input  logic             up,
    input  logic [CNT_W-1:0] load_q,
    input  logic [PRE_W-1:0] pre_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [PRE_W-1:0] pre_cnt_q,
    output logic             terminal
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

    // Interval limits latched at start and at every reload.
    logic [CNT_W-1:0] lim_q;
    logic [PRE_W-1:0] pre_lim_q;
    logic             pre_wrap;

    assign pre_wrap = (pre_cnt_q == '0);
    assign terminal = pre_wrap &&
                      (up ? (cnt_q == lim_q) : (cnt_q == '0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pre_cnt_q <= '0;
            lim_q     <= '0;
            pre_lim_q <= '0;
        end else if (start) begin
            cnt_q     <= start_up ? '0 : load_q;
            pre_cnt_q <= pre_q;
            lim_q     <= load_q;
            pre_lim_q <= pre_q;
        end else if (running && !stop) begin
            if (terminal) begin
                // The reload cycle is counted as part of the period.
                cnt_q     <= up ? '0 : load_q;
                pre_cnt_q <= pre_q;
                lim_q     <= load_q;
                pre_lim_q <= pre_q;
            end else if (pre_wrap) begin
                pre_cnt_q <= pre_lim_q;
                cnt_q     <= up ? (cnt_q + CNT_ONE) : (cnt_q - CNT_ONE);
            end else begin
                pre_cnt_q <= pre_cnt_q - PRE_ONE;
            end
        end
    end

endmodule

// File: rtl/itmr_status.sv
module itmr_status (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic clr,
    input  logic mask,
    output logic raw_q,
    output logic irq
);

    // A new timeout outranks a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       raw_q <= 1'b0;
        else if (timeout) raw_q <= 1'b1;
        else if (clr)     raw_q <= 1'b0;
    end

    assign irq = raw_q & mask;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             ctrl_en,
    input  logic             ctrl_periodic,
    input  logic             ctrl_up,
    input  logic             ctrl_mask,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             pre_we,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             irq_clr,
    output logic             run,
    output logic [CNT_W-1:0] cnt_val,
    output logic [PRE_W-1:0] pre_cnt,
    output logic             irq_raw,
    output logic             irq
);

    tmr_mode_t        mode_q;
    logic [CNT_W-1:0] load_q;
    logic [PRE_W-1:0] pre_q;
    tmr_state_e       state_q;
    logic             start, stop, timeout, terminal;

    itmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_we       (ctrl_we),
        .ctrl_periodic (ctrl_periodic),
        .ctrl_up       (ctrl_up),
        .ctrl_mask     (ctrl_mask),
        .load_we       (load_we),
        .load_val      (load_val),
        .pre_we        (pre_we),
        .pre_val       (pre_val),
        .mode_q        (mode_q),
        .load_q        (load_q),
        .pre_q         (pre_q)
    );

    itmr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .ctrl_en  (ctrl_en),
        .periodic (mode_q.periodic),
        .terminal (terminal),
        .state_q  (state_q),
        .start    (start),
        .stop     (stop),
        .timeout  (timeout)
    );

    itmr_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .running   (state_q == ST_RUN),
        .start_up  (ctrl_up),
        .up        (mode_q.up),
        .load_q    (load_q),
        .pre_q     (pre_q),
        .cnt_q     (cnt_val),
        .pre_cnt_q (pre_cnt),
        .terminal  (terminal)
    );

    itmr_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .timeout (timeout),
        .clr     (irq_clr),
        .mask    (mode_q.mask),
        .raw_q   (irq_raw),
        .irq     (irq)
    );

    assign run = (state_q == ST_RUN);

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_we,
    input logic             irq_clr,
    input logic             run,
    input logic [CNT_W-1:0] cnt_val,
    input logic [PRE_W-1:0] pre_cnt,
    input logic             irq_raw,
    input logic             irq
);

    // R9
    raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw && !irq_clr) |=> irq_raw);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_raw |-> !irq);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctrl_we) |=> (!run && $stable(cnt_val) && $stable(pre_cnt)));

    // R3
    prescale_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctrl_we && pre_cnt != '0) |=>
            (run && $stable(cnt_val) && pre_cnt == $past(pre_cnt) - PRE_W'(1)));

    // R7
    expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctrl_we && !irq_clr) |=> (run || irq_raw));

endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_we (ctrl_we),
    .irq_clr (irq_clr),
    .run     (run),
    .cnt_val (cnt_val),
    .pre_cnt (pre_cnt),
    .irq_raw (irq_raw),
    .irq     (irq)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

    localparam int CNT_W = 16;
    localparam int PRE_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctrl_we = 0, ctrl_en = 0, ctrl_periodic = 0, ctrl_up = 0, ctrl_mask = 0;
    logic             load_we = 0;
    logic [CNT_W-1:0] load_val = '0;
    logic             pre_we = 0;
    logic [PRE_W-1:0] pre_val = '0;
    logic             irq_clr = 0;
    logic             run;
    logic [CNT_W-1:0] cnt_val;
    logic [PRE_W-1:0] pre_cnt;
    logic             irq_raw, irq;

    int n_chk = 0;
    int n_bad = 0;

    interval_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_en(ctrl_en),
        .ctrl_periodic(ctrl_periodic), .ctrl_up(ctrl_up), .ctrl_mask(ctrl_mask),
        .load_we(load_we), .load_val(load_val), .pre_we(pre_we), .pre_val(pre_val),
        .irq_clr(irq_clr), .run(run), .cnt_val(cnt_val), .pre_cnt(pre_cnt),
        .irq_raw(irq_raw), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_ctrl(input logic en, input logic per, input logic up, input logic msk);
        ctrl_we = 1; ctrl_en = en; ctrl_periodic = per; ctrl_up = up; ctrl_mask = msk;
        tick();
        ctrl_we = 0;
    endtask

    task automatic do_load(input int v);
        load_we = 1; load_val = CNT_W'(v);
        tick();
        load_we = 0;
    endtask

    task automatic do_pre(input int v);
        pre_we = 1; pre_val = PRE_W'(v);
        tick();
        pre_we = 0;
    endtask

    task automatic quiesce();
        do_ctrl(0, 0, 0, 0);
        irq_clr = 1;
        tick();
        irq_clr = 0;
    endtask

    task automatic t_reset();
        chk("R1 run", run, 0);
        chk("R1 cnt", cnt_val, 0);
        chk("R1 pre", pre_cnt, 0);
        chk("R1 raw", irq_raw, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_down_prescale();
        quiesce();
        do_load(2); do_pre(3);
        do_ctrl(1, 1, 0, 1);
        chk("R2 run", run, 1);
        chk("R2 cnt", cnt_val, 2);
        chk("R2 pre", pre_cnt, 3);
        ticks(3);
        chk("R3 cnt hold", cnt_val, 2);
        chk("R3 pre", pre_cnt, 0);
        tick();
        chk("R3 cnt step", cnt_val, 1);
        chk("R3 pre wrap", pre_cnt, 3);
        ticks(7);
        chk("R3 terminal cnt", cnt_val, 0);
        chk("R3 terminal pre", pre_cnt, 0);
        chk("R9 raw before", irq_raw, 0);
        tick();
        chk("R6 reload cnt", cnt_val, 2);
        chk("R6 reload pre", pre_cnt, 3);
        chk("R9 raw set", irq_raw, 1);
        chk("R6 still run", run, 1);
    endtask

    task automatic t_lock();
        quiesce();
        do_load(6); do_pre(2);
        irq_clr = 1;
        do_ctrl(1, 1, 0, 1);
        for (int k = 1; k <= 210; k++) begin
            tick();
            // R5 and R9: pulse only on multiples of 21, clear held high
            chk("R5 timeout phase", irq_raw, (k % 21 == 0) ? 1 : 0);
        end
        irq_clr = 0;
    endtask

    task automatic t_up_oneshot();
        quiesce();
        do_load(3); do_pre(1);
        do_ctrl(1, 0, 1, 1);
        chk("R2 up start cnt", cnt_val, 0);
        chk("R2 up start pre", pre_cnt, 1);
        ticks(2);
        chk("R4 up step", cnt_val, 1);
        ticks(5);
        chk("R4 up terminal cnt", cnt_val, 3);
        chk("R4 up terminal pre", pre_cnt, 0);
        chk("R7 still run", run, 1);
        tick();
        chk("R4 up reload", cnt_val, 0);
        chk("R7 run cleared", run, 0);
        chk("R7 raw set", irq_raw, 1);
        chk("R10 irq", irq, 1);
        ticks(3);
        chk("R7 hold cnt", cnt_val, 0);
        chk("R7 hold pre", pre_cnt, 1);
        chk("R7 stays idle", run, 0);
    endtask

    task automatic t_down_oneshot();
        quiesce();
        do_load(2); do_pre(0);
        do_ctrl(1, 0, 0, 0);
        ticks(2);
        chk("R7 down at 0", cnt_val, 0);
        tick();
        chk("R7 down reload", cnt_val, 2);
        chk("R7 down run off", run, 0);
        chk("R7 down raw", irq_raw, 1);
        chk("R10 masked", irq, 0);
    endtask

    task automatic t_load_midrun();
        quiesce();
        do_load(5); do_pre(0);
        do_ctrl(1, 1, 0, 1);
        ticks(2);
        do_load(2);
        chk("R8 current kept", cnt_val, 2);
        ticks(2);
        chk("R8 reaches 0", cnt_val, 0);
        tick();
        chk("R8 new load", cnt_val, 2);
        ticks(2);
        chk("R8 new period 0", cnt_val, 0);
        tick();
        chk("R8 new period reload", cnt_val, 2);
    endtask

    task automatic t_mask();
        quiesce();
        do_load(1); do_pre(0);
        do_ctrl(1, 1, 0, 0);
        ticks(2);
        chk("R10 raw", irq_raw, 1);
        chk("R10 masked irq", irq, 0);
        do_ctrl(0, 1, 0, 0);
        ticks(2);
        chk("R9 sticky idle", irq_raw, 1);
        do_ctrl(0, 1, 0, 1);
        chk("R10 unmasked irq", irq, 1);
        irq_clr = 1;
        tick();
        irq_clr = 0;
        chk("R9 cleared", irq_raw, 0);
        chk("R10 irq low", irq, 0);
    endtask

    task automatic t_stop();
        quiesce();
        do_load(9); do_pre(0);
        do_ctrl(1, 1, 0, 0);
        ticks(3);
        chk("R11 pre-stop", cnt_val, 6);
        do_ctrl(0, 1, 0, 0);
        chk("R11 run off", run, 0);
        chk("R11 cnt frozen", cnt_val, 6);
        ticks(4);
        chk("R11 cnt held", cnt_val, 6);
        chk("R11 no flag", irq_raw, 0);
    endtask

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #12;
        t_reset();
        rst_n = 1;
        tick();
        t_down_prescale();
        t_lock();
        t_up_oneshot();
        t_down_oneshot();
        t_load_midrun();
        t_mask();
        t_stop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule